// File: doc/BRIEF.md
# Bidirectional Bit Scan Unit

This unit locates a set bit inside a source word. A request carries the source value, a width select that picks a 16-bit or a 32-bit operand, and a direction select. In forward mode the unit reports the position of the lowest 1 bit. In reverse mode it reports the position of the highest 1 bit. In both modes the position is an unsigned offset measured from bit 0.

The result comes back one clock after the request as a 5-bit index, a zero flag and a one-cycle valid pulse. If the operand is all zeros, the zero flag goes high and the index register keeps the value it already held. The search itself is combinational: the operand is conditioned, passed through one lowest-one priority encoder and then registered. A reverse scan is made by mirroring the operand before the encoder and mirroring the position after it.

Top module: `bit_scan_unit`

## Requirements
- R1: When `scan_rev` is 0 and the operand is non-zero, `res_index` is the position of the least significant 1 bit of the operand.
- R2: When `scan_rev` is 1 and the operand is non-zero, `res_index` is the position of the most significant 1 bit of the operand, counted from bit 0.
- R3: When the operand is zero, `res_zero` is 1 in the response.
- R4: When the operand is non-zero, `res_zero` is 0 in the response.
- R5: When the operand is zero, `res_index` keeps the value it had before the request.
- R6: When `half_sel` is 1, the operand is `src[15:0]`, and bits 31..16 of `src` have no effect on `res_index` or `res_zero`.
- R7: For a non-zero operand with `half_sel` 1, bit 4 of `res_index` is 0.
- R8: `res_valid` is high in the cycle after each cycle in which `req_valid` is high, and low in the cycle after each cycle in which `req_valid` is low.
- R9: In a cycle with no request, `res_index` and `res_zero` do not change.
- R10: While `rst_n` is low, `res_valid`, `res_zero` and `res_index` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; the other request inputs are sampled when it is high |
| src | input | 32 | Source operand |
| half_sel | input | 1 | 1: 16-bit operand, 0: 32-bit operand |
| scan_rev | input | 1 | 0: forward (lowest set bit), 1: reverse (highest set bit) |
| res_valid | output | 1 | High for one cycle when a result is presented |
| res_index | output | 5 | Bit position found |
| res_zero | output | 1 | 1 when the operand had no set bit |

## Verification
The bench sweeps every source with one or two bits set, in all four width/direction combinations. This catches an encoder that prefers the wrong end of the word, or a reverse mirror that is off by one and returns neighbouring positions. It also fills the upper half with junk while the lower half is zero or sparse in 16-bit mode. A design that forgot to mask the upper half would then report positions of 16 or more and clear the zero flag. It issues zero operands right after known non-zero results, so a design that reloads the index on a zero operand shows up as a changed index, and it inserts idle cycles to expose results that drift without a request.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic {
    SCAN_FWD = 1'b0,
    SCAN_REV = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/bscan_operand_prep.sv
// Conditions the raw source: drops the upper half in narrow mode and
// mirrors the word for a reverse scan, so a single lowest-one encoder
// serves both directions.
module bscan_operand_prep #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic [DATA_W-1:0] src,
  input  logic              half_sel,
  input  bscan_pkg::scan_dir_e dir,
  output logic [DATA_W-1:0] vec
);
  logic [DATA_W-1:0] narrow_mask;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] mirrored;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_mask
      if (gi < NARROW_W) begin : g_keep
        assign narrow_mask[gi] = 1'b1;
      end else begin : g_drop
        assign narrow_mask[gi] = ~half_sel;
      end
    end
    for (gi = 0; gi < DATA_W; gi++) begin : g_mirror
      assign mirrored[gi] = masked[DATA_W-1-gi];
    end
  endgenerate

  always_comb begin
    masked = src & narrow_mask;
    vec    = (dir == bscan_pkg::SCAN_REV) ? mirrored : masked;
  end
endmodule

// File: rtl/bscan_prio_enc.sv
// Lowest-one priority encoder built as a binary tree of pair merges.
module bscan_prio_enc #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] vec,
  output logic [IDX_W-1:0]  pos,
  output logic              any
);
  // Level l holds DATA_W>>l nodes, each with a hit flag and an l-bit position.
  logic [DATA_W-1:0]       hit [IDX_W+1];
  logic [IDX_W-1:0]        loc [IDX_W+1][DATA_W];

  genvar lv, nd;
  generate
    for (nd = 0; nd < DATA_W; nd++) begin : g_leaf
      assign hit[0][nd] = vec[nd];
      assign loc[0][nd] = '0;
    end
    for (nd = 0; nd < DATA_W; nd++) begin : g_lvl0_pad
      // unused upper node slots at every level are tied off below
    end
    for (lv = 1; lv <= IDX_W; lv++) begin : g_level
      localparam int NODES = DATA_W >> lv;
      for (nd = 0; nd < DATA_W; nd++) begin : g_node
        if (nd < NODES) begin : g_live
          logic lo_hit;
          assign lo_hit        = hit[lv-1][2*nd];
          assign hit[lv][nd]   = lo_hit | hit[lv-1][2*nd+1];
          always_comb begin
            loc[lv][nd] = lo_hit ? loc[lv-1][2*nd] : loc[lv-1][2*nd+1];
            loc[lv][nd][lv-1] = ~lo_hit;
          end
        end else begin : g_tie
          assign hit[lv][nd] = 1'b0;
          assign loc[lv][nd] = '0;
        end
      end
    end
  endgenerate

  assign any = hit[IDX_W][0];
  assign pos = loc[IDX_W][0];
endmodule

// File: rtl/bscan_result_reg.sv
module bscan_result_reg #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] new_index,
  input  logic             new_zero,
  output logic             res_valid,
  output logic [IDX_W-1:0] res_index,
  output logic             res_zero
);
  logic             valid_d;
  logic [IDX_W-1:0] index_d;
  logic             zero_d;
  logic             index_en;

  always_comb begin
    valid_d  = load;
    index_en = load & ~new_zero;
    index_d  = index_en ? new_index : res_index;
    zero_d   = load ? new_zero : res_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_index <= '0;
      res_zero  <= 1'b0;
    end else begin
      res_valid <= valid_d;
      res_index <= index_d;
      res_zero  <= zero_d;
    end
  end
endmodule

// File: rtl/bit_scan_unit.sv
module bit_scan_unit #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] src,
  input  logic              half_sel,
  input  logic              scan_rev,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_index,
  output logic              res_zero
);
  bscan_pkg::scan_dir_e dir;
  logic [DATA_W-1:0]    vec;
  logic [IDX_W-1:0]     enc_pos;
  logic                 enc_any;
  logic [IDX_W-1:0]     index_c;

  assign dir = scan_rev ? bscan_pkg::SCAN_REV : bscan_pkg::SCAN_FWD;

  bscan_operand_prep #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) prep_i (
    .src      (src),
    .half_sel (half_sel),
    .dir      (dir),
    .vec      (vec)
  );

  bscan_prio_enc #(.DATA_W(DATA_W)) enc_i (
    .vec (vec),
    .pos (enc_pos),
    .any (enc_any)
  );

  always_comb begin
    if (dir == bscan_pkg::SCAN_REV) index_c = IDX_W'(DATA_W - 1) - enc_pos;
    else                            index_c = enc_pos;
  end

  bscan_result_reg #(.IDX_W(IDX_W)) reg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (req_valid),
    .new_index (index_c),
    .new_zero  (~enc_any),
    .res_valid (res_valid),
    .res_index (res_index),
    .res_zero  (res_zero)
  );
endmodule

// File: rtl/bit_scan_unit_chk.sv
module bit_scan_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [DATA_W-1:0] src,
  input logic              half_sel,
  input logic              scan_rev,
  input logic              res_valid,
  input logic [IDX_W-1:0]  res_index,
  input logic              res_zero
);
  localparam logic [DATA_W-1:0] TOP_ONE = {1'b1, {(DATA_W-1){1'b0}}};

  // R1
  property fwd_lowest_p;
    @(posedge clk) disable iff (!rst_n)
      (res_valid && !res_zero && !$past(scan_rev) && !$past(half_sel))
      |-> (($past(src) << (DATA_W - 1 - int'(res_index))) == TOP_ONE);
  endproperty
  fwd_lowest_chk: assert property (fwd_lowest_p);

  // R2
  property rev_highest_p;
    @(posedge clk) disable iff (!rst_n)
      (res_valid && !res_zero && $past(scan_rev) && !$past(half_sel))
      |-> (($past(src) >> res_index) == DATA_W'(1));
  endproperty
  rev_highest_chk: assert property (rev_highest_p);

  // R3
  property zero_set_p;
    @(posedge clk) disable iff (!rst_n)
      (req_valid && src[NARROW_W-1:0] == '0 && (half_sel || src == '0)) |=> res_zero;
  endproperty
  zero_set_chk: assert property (zero_set_p);

  // R4
  property zero_clr_p;
    @(posedge clk) disable iff (!rst_n)
      (req_valid && src[NARROW_W-1:0] != '0) |=> !res_zero;
  endproperty
  zero_clr_chk: assert property (zero_clr_p);

  // R5
  property hold_on_zero_p;
    @(posedge clk) disable iff (!rst_n)
      (res_valid && res_zero) |-> $stable(res_index);
  endproperty
  hold_on_zero_chk: assert property (hold_on_zero_p);

  // R7
  property narrow_top_p;
    @(posedge clk) disable iff (!rst_n)
      (res_valid && !res_zero && $past(half_sel)) |-> !res_index[IDX_W-1];
  endproperty
  narrow_top_chk: assert property (narrow_top_p);

  // R8
  property valid_follow_p;
    @(posedge clk) disable iff (!rst_n)
      1'b1 |=> (res_valid == $past(req_valid));
  endproperty
  valid_follow_chk: assert property (valid_follow_p);

  // R9
  property idle_hold_p;
    @(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(res_index) && $stable(res_zero));
  endproperty
  idle_hold_chk: assert property (idle_hold_p);
endmodule

bind bit_scan_unit bit_scan_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .src       (src),
  .half_sel  (half_sel),
  .scan_rev  (scan_rev),
  .res_valid (res_valid),
  .res_index (res_index),
  .res_zero  (res_zero)
);

// File: tb/bit_scan_unit_tb_top.sv
module bit_scan_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] src;
  logic        half_sel;
  logic        scan_rev;
  logic        res_valid;
  logic [4:0]  res_index;
  logic        res_zero;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [4:0] model_idx;

  bit_scan_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .src(src),
    .half_sel(half_sel), .scan_rev(scan_rev), .res_valid(res_valid),
    .res_index(res_index), .res_zero(res_zero)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One request, result checked at the negedge after its capture edge.
  task automatic scan(input logic [31:0] s, input bit half, input bit rev);
    logic [31:0] op;
    int lo, hi;
    op = half ? (s & 32'h0000_FFFF) : s;
    lo = -1; hi = -1;
    for (int b = 0; b < 32; b++) if (op[b]) begin
      if (lo < 0) lo = b;
      hi = b;
    end
    @(negedge clk);
    req_valid = 1'b1; src = s; half_sel = half; scan_rev = rev;
    @(negedge clk);
    req_valid = 1'b0; src = $urandom;
    check("R8 valid", {31'd0, res_valid}, 32'd1);
    if (op == 32'd0) begin
      check("R3 zero set", {31'd0, res_zero}, 32'd1);
      check("R5 index held", {27'd0, res_index}, {27'd0, model_idx});
    end else begin
      model_idx = rev ? 5'(hi) : 5'(lo);
      check("R4 zero clear", {31'd0, res_zero}, 32'd0);
      if (rev) check("R2 highest", {27'd0, res_index}, 32'(hi));
      else     check("R1 lowest", {27'd0, res_index}, 32'(lo));
      if (half) check("R7 top bit", {31'd0, res_index[4]}, 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic zero_before;
    logic [4:0] idx_before;
    rst_n = 1'b0; req_valid = 1'b0; src = '0; half_sel = 1'b0; scan_rev = 1'b0;
    model_idx = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", {31'd0, res_valid}, 32'd0);
    check("R10 index", {27'd0, res_index}, 32'd0);
    check("R10 zero", {31'd0, res_zero}, 32'd0);
    rst_n = 1'b1;

    // Sweep all one- and two-bit sources in every mode.
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 32; i++)
        for (int j = i; j < 32; j++)
          scan((32'd1 << i) | (32'd1 << j), m[0], m[1]);

    // R6: junk in the upper half while narrow.
    for (int k = 0; k < 64; k++) begin
      logic [31:0] junk;
      junk = {16'($urandom | 1), 16'd0};
      scan(junk | (32'd1 << (k % 16)) | (32'd1 << ((k * 7) % 16)), 1'b1, k[0]);
      scan(junk, 1'b1, k[1]);   // R6 upper bits only: zero operand
      scan(junk, 1'b0, k[1]);   // same word as 32-bit operand is non-zero
    end

    // R5: zero operands following known results.
    scan(32'h8000_0000, 1'b0, 1'b1);
    scan(32'h0, 1'b0, 1'b0);
    scan(32'h0, 1'b1, 1'b1);

    // R8/R9: idle cycles hold outputs.
    for (int k = 0; k < 32; k++) begin
      scan($urandom, k[0], k[1]);
      idx_before = res_index; zero_before = res_zero;
      @(negedge clk);
      check("R8 no valid", {31'd0, res_valid}, 32'd0);
      check("R9 index idle", {27'd0, res_index}, {27'd0, idx_before});
      check("R9 zero idle", {31'd0, res_zero}, {31'd0, zero_before});
    end

    // Back-to-back requests.
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      req_valid = 1'b1; src = 32'd1 << k; half_sel = 1'b0; scan_rev = k[0];
      @(negedge clk);
      check("R8 b2b valid", {31'd0, res_valid}, 32'd1);
      check(k[0] ? "R2 b2b" : "R1 b2b", {27'd0, res_index}, 32'(k));
      model_idx = 5'(k);
    end
    req_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule